// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block divides the feedback clock of a frequency synthesizer loop. The feedback clock is the local oscillator already halved. The block makes one output pulse for every N feedback-clock cycles, with N = 16·M + S. M is a 13-bit main count and S is a 4-bit swallow count. Each output period has M prescaler cycles. The first S of them last 17 input cycles and the other M − S last 16. That is how S extra input cycles are swallowed on top of 16·M.

A second divider runs from the reference (crystal) clock. It makes one pulse every 2^(k+1) reference cycles, where k is a 3-bit code. The two pulse trains go to a phase comparator outside the block.

The block reads new settings only at a period boundary, so a period is never cut short or stretched partway through. It rejects a setting with S ≥ M. One synchronous reset clears both dividers, so their first pulses come out aligned whenever the two ratios match.

Top module: `pfdiv_top`

## Requirements
- R1: While the setting is valid, `divOut` pulses exactly once every N = 16·M + S cycles of `clk`, where M = `mainDiv` and S = `swallowDiv`, both unsigned binary.
- R2: Within one output period, the prescaler counts 17 input cycles for each of the first S prescaler cycles and 16 input cycles for each of the other M − S. It never counts past 17.
- R3: `mainDiv` and `swallowDiv` are sampled only on the clock edge that ends an output period. That edge is the one that raises `divOut`. A change made at any other time first affects the period after the next boundary.
- R4: `cfgBad` is high, combinationally, whenever `swallowDiv` ≥ `mainDiv`, and this includes `mainDiv` = 0. A boundary that sees `cfgBad` high keeps the previous ratio.
- R5: Each `divOut` pulse is high for exactly one `clk` cycle.
- R6: The reference divider pulses `refOut` once every 2^(k+1) `refClk` cycles, where k = `refCode` (0 gives 2 and 7 gives 256). Each pulse is one `refClk` cycle wide.
- R7: `refCode` is sampled only in reset and on the `refClk` edge that raises `refOut`.
- R8: `rstN` is a synchronous, active-low reset. While it is low, `divOut` and `refOut` are 0 and the current port settings are captured. After `rstN` rises, the first `divOut` is high N edges later and the first `refOut` is high 2^(k+1) edges later, so equal ratios give coincident first pulses.
- R9: A setting with S ≥ M that is present during reset is replaced by M = 1, S = 0, giving a divide-by-16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Feedback clock (halved oscillator) |
| refClk | input | 1 | Reference clock |
| rstN | input | 1 | Synchronous active-low reset, sampled in both clock domains |
| mainDiv | input | 13 | Main count M |
| swallowDiv | input | 4 | Swallow count S |
| refCode | input | 3 | Reference ratio code k, ratio 2^(k+1) |
| divOut | output | 1 | One-cycle pulse per N feedback cycles |
| refOut | output | 1 | One-cycle pulse per reference period |
| cfgBad | output | 1 | High while swallowDiv ≥ mainDiv |

## Verification
The hardest case to reach from the ports is a setting that changes while a period is running. Its effect shows only in the period after the next boundary, never in the current one. The stimulus writes the new M and S right after a pulse and then measures two periods in a row: the first must still have the old length and the second the new length. The same two-period method shows a rejected S ≥ M setting holding the old ratio, and a reference code changed after a pulse taking effect one period late.

// File: rtl/pfdiv_pkg.sv
package pfdiv_pkg;
  // Strobes from the control to the counter datapath
  typedef struct packed {
    logic swallowPhase; // current prescaler cycle lasts one extra input cycle
    logic preWrap;      // prescaler ends its cycle on this edge
    logic frameEnd;     // output period ends on this edge
    logic loadOk;       // port setting is legal (S < M)
  } divStrobe_t;
endpackage

// File: rtl/pfdiv_datapath.sv
module pfdiv_datapath
  import pfdiv_pkg::*;
#(
  parameter int M_W   = 13,
  parameter int S_W   = 4,
  parameter int DEF_M = 1,
  parameter int DEF_S = 0,
  localparam int PRE_W = S_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [M_W-1:0]   mainDiv,
  input  logic [S_W-1:0]   swallowDiv,
  input  divStrobe_t       stb,
  output logic [PRE_W-1:0] preCnt,
  output logic [M_W-1:0]   mainCnt,
  output logic [M_W-1:0]   activeM,
  output logic [S_W-1:0]   activeS
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      mainCnt <= '0;
      if (stb.loadOk) begin
        activeM <= mainDiv;
        activeS <= swallowDiv;
      end else begin
        activeM <= M_W'(DEF_M);
        activeS <= S_W'(DEF_S);
      end
    end else if (stb.frameEnd) begin
      preCnt  <= '0;
      mainCnt <= '0;
      if (stb.loadOk) begin
        activeM <= mainDiv;
        activeS <= swallowDiv;
      end
    end else if (stb.preWrap) begin
      preCnt  <= '0;
      mainCnt <= mainCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

endmodule

// File: rtl/pfdiv_control.sv
module pfdiv_control
  import pfdiv_pkg::*;
#(
  parameter int M_W = 13,
  parameter int S_W = 4,
  localparam int PRE_W   = S_W + 1,
  localparam int PRE_MOD = 2 ** S_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PRE_W-1:0] preCnt,
  input  logic [M_W-1:0]   mainCnt,
  input  logic [M_W-1:0]   activeM,
  input  logic [S_W-1:0]   activeS,
  input  logic [M_W-1:0]   mainDiv,
  input  logic [S_W-1:0]   swallowDiv,
  output divStrobe_t       stb,
  output logic             divOut,
  output logic             cfgBad
);

  logic [M_W-1:0] activeSExt;
  logic [M_W-1:0] portSExt;

  always_comb begin
    activeSExt       = {{(M_W - S_W){1'b0}}, activeS};
    portSExt         = {{(M_W - S_W){1'b0}}, swallowDiv};
    stb.swallowPhase = mainCnt < activeSExt;
    stb.preWrap      = stb.swallowPhase ? (preCnt == PRE_W'(PRE_MOD))
                                        : (preCnt == PRE_W'(PRE_MOD - 1));
    stb.frameEnd     = stb.preWrap && (mainCnt == activeM - 1'b1);
    stb.loadOk       = portSExt < mainDiv;
    cfgBad           = !stb.loadOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) divOut <= 1'b0;
    else       divOut <= stb.frameEnd;
  end

endmodule

// File: rtl/pfdiv_refdiv.sv
module pfdiv_refdiv #(
  parameter int CODE_W = 3,
  localparam int CNT_W = 2 ** CODE_W
) (
  input  logic              refClk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] refCode,
  output logic              refOut
);

  logic [CODE_W-1:0] selAct;
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W:0]   shiftAmt;
  logic [CNT_W:0]    ratio;
  logic              refTc;

  always_comb begin
    shiftAmt = {1'b0, selAct} + 1'b1;
    ratio    = (CNT_W + 1)'(1) << shiftAmt;
    refTc    = {1'b0, cnt} == (ratio - 1'b1);
  end

  always_ff @(posedge refClk) begin
    if (!rstN) begin
      cnt    <= '0;
      selAct <= refCode;
      refOut <= 1'b0;
    end else if (refTc) begin
      cnt    <= '0;
      selAct <= refCode;
      refOut <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      refOut <= 1'b0;
    end
  end

endmodule

// File: rtl/pfdiv_top.sv
module pfdiv_top
  import pfdiv_pkg::*;
#(
  parameter int M_W    = 13,
  parameter int S_W    = 4,
  parameter int CODE_W = 3,
  localparam int PRE_W = S_W + 1
) (
  input  logic              clk,
  input  logic              refClk,
  input  logic              rstN,
  input  logic [M_W-1:0]    mainDiv,
  input  logic [S_W-1:0]    swallowDiv,
  input  logic [CODE_W-1:0] refCode,
  output logic              divOut,
  output logic              refOut,
  output logic              cfgBad
);

  divStrobe_t       stb;
  logic [PRE_W-1:0] preCnt;
  logic [M_W-1:0]   mainCnt;
  logic [M_W-1:0]   activeM;
  logic [S_W-1:0]   activeS;

  pfdiv_control #(.M_W(M_W), .S_W(S_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .preCnt(preCnt), .mainCnt(mainCnt),
    .activeM(activeM), .activeS(activeS), .mainDiv(mainDiv),
    .swallowDiv(swallowDiv), .stb(stb), .divOut(divOut), .cfgBad(cfgBad)
  );

  pfdiv_datapath #(.M_W(M_W), .S_W(S_W)) dp_i (
    .clk(clk), .rstN(rstN), .mainDiv(mainDiv), .swallowDiv(swallowDiv),
    .stb(stb), .preCnt(preCnt), .mainCnt(mainCnt),
    .activeM(activeM), .activeS(activeS)
  );

  pfdiv_refdiv #(.CODE_W(CODE_W)) ref_i (
    .refClk(refClk), .rstN(rstN), .refCode(refCode), .refOut(refOut)
  );

endmodule

// File: rtl/pfdiv_chk.sv
module pfdiv_chk #(
  parameter int M_W = 13,
  parameter int S_W = 4,
  localparam int PRE_W   = S_W + 1,
  localparam int PRE_MOD = 2 ** S_W
) (
  input logic             clk,
  input logic             refClk,
  input logic             rstN,
  input logic             divOut,
  input logic             refOut,
  input logic             cfgBad,
  input logic             frameEnd,
  input logic [PRE_W-1:0] preCnt,
  input logic [M_W-1:0]   mainCnt,
  input logic [M_W-1:0]   activeM,
  input logic [S_W-1:0]   activeS
);

  AST_DIV_ONE_WIDE: assert property (@(posedge clk) disable iff (!rstN) divOut |=> !divOut); // R5
  AST_REF_ONE_WIDE: assert property (@(posedge refClk) disable iff (!rstN) refOut |=> !refOut); // R6
  AST_ACTIVE_LEGAL: assert property (@(posedge clk) disable iff (!rstN) {{(M_W - S_W){1'b0}}, activeS} < activeM); // R4
  AST_HOLD_ON_BAD: assert property (@(posedge clk) disable iff (!rstN) (frameEnd && cfgBad) |=> ($stable(activeM) && $stable(activeS))); // R4
  AST_NO_MIDFRAME_LOAD: assert property (@(posedge clk) disable iff (!rstN) !frameEnd |=> ($stable(activeM) && $stable(activeS))); // R3
  AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rstN) preCnt <= PRE_W'(PRE_MOD)); // R2
  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rstN) frameEnd |=> (preCnt == '0 && mainCnt == '0 && divOut)); // R1

endmodule

bind pfdiv_top pfdiv_chk #(.M_W(M_W), .S_W(S_W)) chk_i (
  .clk(clk), .refClk(refClk), .rstN(rstN), .divOut(divOut), .refOut(refOut),
  .cfgBad(cfgBad), .frameEnd(stb.frameEnd), .preCnt(preCnt), .mainCnt(mainCnt),
  .activeM(activeM), .activeS(activeS)
);

// File: tb/pfdiv_top_tb_top.sv
module pfdiv_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [12:0] mainDiv;
  logic [3:0]  swallowDiv;
  logic [2:0]  refCode;
  logic        divOut, refOut, cfgBad;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;

  always #10 clk = ~clk;

  pfdiv_top dut_i (
    .clk(clk), .refClk(clk), .rstN(rstN), .mainDiv(mainDiv),
    .swallowDiv(swallowDiv), .refCode(refCode),
    .divOut(divOut), .refOut(refOut), .cfgBad(cfgBad)
  );

  // Main-divider vectors: M, S and expected period in input cycles
  localparam int NV = 8;
  localparam int VEC_M[NV] = '{1, 2, 3, 5, 16, 100, 512, 40};
  localparam int VEC_S[NV] = '{0, 1, 2, 4, 15, 7, 15, 0};
  localparam int VEC_N[NV] = '{16, 33, 50, 84, 271, 1607, 8207, 640};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitDiv();
    do @(negedge clk); while (!divOut);
  endtask

  task automatic measDiv(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!divOut);
  endtask

  task automatic waitRef();
    do @(negedge clk); while (!refOut);
  endtask

  task automatic measRef(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!refOut);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    rstN = 1'b0; mainDiv = 13'd1; swallowDiv = 4'd0; refCode = 3'd3;
    repeat (3) @(negedge clk);
    check("R8 divOut in reset", int'(divOut), 0);
    check("R8 refOut in reset", int'(refOut), 0);
    check("R4 cfgBad legal", int'(cfgBad), 0);

    // R8: first pulses land N and 2^(k+1) edges after release, coincident
    rstN = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!divOut);
    check("R8 first divOut delay", n, 16);
    check("R8 refOut aligned", int'(refOut), 1);
    @(negedge clk);
    check("R5 divOut width", int'(divOut), 0);
    check("R6 refOut width", int'(refOut), 0);

    // R1/R2: table of ratios (S = 15 exercises the longest swallow phase)
    for (int i = 0; i < NV; i++) begin
      mainDiv = 13'(VEC_M[i]); swallowDiv = 4'(VEC_S[i]);
      waitDiv();
      measDiv(n);
      check("R1 R2 period", n, VEC_N[i]);
    end

    // R3: update after a boundary applies only at the next one
    mainDiv = 13'd2; swallowDiv = 4'd0;
    waitDiv();
    mainDiv = 13'd3; swallowDiv = 4'd1;
    measDiv(n);
    check("R3 old period kept", n, 32);
    measDiv(n);
    check("R3 new period", n, 49);

    // R4: illegal settings flagged and ignored
    swallowDiv = 4'd3; #1;
    check("R4 cfgBad S==M", int'(cfgBad), 1);
    waitDiv();
    measDiv(n);
    check("R4 ratio held", n, 49);
    mainDiv = 13'd0; swallowDiv = 4'd0; #1;
    check("R4 cfgBad M zero", int'(cfgBad), 1);
    mainDiv = 13'd16; swallowDiv = 4'd15; #1;
    check("R4 cfgBad S=M-1", int'(cfgBad), 0);

    // R6: every reference code
    for (int k = 0; k < 8; k++) begin
      refCode = 3'(k);
      waitRef();
      measRef(n);
      check("R6 ref ratio", n, 2 << k);
    end
    @(negedge clk);
    check("R6 refOut width", int'(refOut), 0);

    // R7: code change takes effect one reference period later
    waitRef();
    refCode = 3'd0;
    measRef(n);
    check("R7 old ref period kept", n, 256);
    measRef(n);
    check("R7 new ref period", n, 2);

    // R9: illegal setting during reset falls back to divide-by-16
    @(negedge clk);
    rstN = 1'b0; mainDiv = 13'd2; swallowDiv = 4'd2;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!divOut);
    check("R9 default ratio", n, 16);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule